// File: doc/BRIEF.md
# BCD Watchdog Timer with Expiry Steering

This block watches a processor for signs of life. Software writes a time-out into two byte registers as four BCD digits. The upper register holds the tens and units of seconds. The lower register holds the tenths and hundredths. A BCD down-counter steps once per 100 Hz tick. Each read or write of either time-out register restarts the period. If no such access arrives before the count runs out, the block records the expiry and reloads itself.

A control register holds an enable bit and a steering bit. When the enable bit is set, an expiry either drives an interrupt line or produces a reset pulse of fixed length, depending on the steering bit. Choosing the reset path also clears the enable bit in the same clock edge that starts the pulse. Software clears the flags either by reading the flag register or by writing zeros to the flag bits. Both pin outputs are drive enables for active-low open-drain pins, so a 1 means the pin is pulled low.

Register map, selected by `bus_addr`:
- 0x0C: hundredths digit in [3:0], tenths digit in [7:4].
- 0x0D: units-of-seconds digit in [3:0], tens-of-seconds digit in [7:4].
- 0x0E: flags. Bit 0 is the interrupt-request flag and bit 1 is the watchdog flag. The other bits read as 0.
- 0x0F: control. Bit 0 is steering (0 selects the interrupt, 1 selects the reset pulse) and bit 1 is enable. The other bits read as 0.

Top module: `wdt_bcd_steer`

## Requirements
- R1: After synchronous reset, all four registers read 0x00, and `wd_flag`, `irq_flag`, `irq_drive` and `rst_drive` are 0.
- R2: With time-out digits T1 T0 . t1 t0 (0x0D = {T1,T0}, 0x0C = {t1,t0}), the period is N = 1000·T1 + 100·T0 + 10·t1 + t0 ticks. The N-th tick after a restart sets `wd_flag`, and the flag is visible on the clock edge of that tick. Ticks 1 to N-1 leave it clear.
- R3: A single-cycle access (`bus_sel`=1, read or write) to 0x0C or 0x0D restarts the full period of N ticks, using any value written in that cycle. A tick in the same cycle as the access is not counted.
- R4: While both time-out registers hold 0x00, no tick ever produces an expiry.
- R5: Every expiry sets `wd_flag`, whether or not enable is set. With enable at 0, an expiry leaves `irq_flag`, `irq_drive` and `rst_drive` unchanged.
- R6: With enable=1 and steering=0, an expiry sets `wd_flag` and `irq_flag` and raises `irq_drive`. `rst_drive` stays 0.
- R7: With enable=1 and steering=1, an expiry sets `wd_flag` and `irq_flag` and raises `rst_drive`. In the same edge, the enable bit in 0x0F is cleared. `rst_drive` stays high through the next RST_TICKS-1 ticks and falls on the RST_TICKS-th tick. `irq_drive` stays 0.
- R8: After an expiry, the counter reloads on its own. The next expiry follows N ticks later with no register access in between.
- R9: A read of 0x0E returns the flags as they stood before the read, then clears both flags and releases `irq_drive`.
- R10: A write to 0x0E clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. `irq_drive` falls exactly when `irq_flag` is cleared.
- R11: An expiry in the same cycle as a flag clear wins: the flags it sets read as 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | Single-cycle pulse marking one hundredth of a second |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address during a read, 0 otherwise |
| wd_flag | output | 1 | Watchdog expiry flag |
| irq_flag | output | 1 | Interrupt-request flag |
| irq_drive | output | 1 | Pull the interrupt pin low |
| rst_drive | output | 1 | Pull the reset pin low |

## Verification
Every registered result lands on the clock edge that samples its stimulus. Flags, pin enables and the enable bit are therefore due one edge after a tick or access cycle, while read data is due within the access cycle itself. The bench drives each stimulus for one cycle starting at a falling edge. It captures read data just before the rising edge and checks registered outputs at the following falling edge, so each check lands in the first cycle where the result is due. Periods are counted in ticks. The bench checks the flag both one tick before and exactly at the computed N, and counts the reset pulse tick by tick against RST_TICKS.

// File: rtl/wdt_bcd_pkg.sv
// Package: register addresses, bit positions and the bus request type
// shared by the watchdog modules. Assumes byte-wide registers.
package wdt_bcd_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DIGIT_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_TO_LO = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_TO_HI = 5'h0D;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 5'h0E;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'h0F;

    localparam int unsigned FLAG_IRQ_BIT   = 0;
    localparam int unsigned FLAG_WD_BIT    = 1;
    localparam int unsigned CTRL_STEER_BIT = 0;
    localparam int unsigned CTRL_EN_BIT    = 1;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;
endpackage

// File: rtl/wdt_bcd_counter.sv
// BCD down-counter: holds DIGITS decimal digits and steps down one unit
// per tick while armed. A load restarts it from load_val. When a tick
// arrives on a count of one, it pulses expire and reloads. Assumes
// load_val holds valid BCD digits.
module wdt_bcd_counter #(
    parameter int unsigned DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  armed,
    input  logic                  load,
    input  logic [4*DIGITS-1:0]   load_val,
    input  logic [4*DIGITS-1:0]   reload_val,
    output logic                  expire
);
    localparam int unsigned CW = 4 * DIGITS;

    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   cnt_dec;
    logic [DIGITS:0] borrow;
    logic            at_one;

    assign borrow[0] = 1'b1;

    // Per-digit decrement with a borrow chain, least significant digit first.
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [3:0] dig;
        assign dig = cnt_q[4*d +: 4];
        always_comb begin
            if (!borrow[d]) begin
                cnt_dec[4*d +: 4] = dig;
            end else if (dig == 4'd0) begin
                cnt_dec[4*d +: 4] = 4'd9;
            end else begin
                cnt_dec[4*d +: 4] = dig - 4'd1;
            end
        end
        assign borrow[d+1] = borrow[d] && (dig == 4'd0);
    end

    assign at_one = (cnt_q == CW'(1));
    assign expire = tick && armed && !load && at_one;

    // Count register: a load wins, then an expiry reloads, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && armed) begin
            cnt_q <= at_one ? reload_val : cnt_dec;
        end
    end
endmodule

// File: rtl/wdt_rst_pulse.sv
// Reset pulse timer: on start it holds active for PULSE_TICKS ticks.
// A start in a tick cycle takes priority, so the pulse covers the
// PULSE_TICKS ticks that follow.
module wdt_rst_pulse #(
    parameter int unsigned PULSE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic active
);
    localparam int unsigned PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] left_q;

    // Remaining-tick counter for the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= PW'(PULSE_TICKS);
        end else if (tick && left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/wdt_regfile.sv
// Register file: time-out digits, control bits, flags and the interrupt
// pin state. Decodes single-cycle bus accesses, builds the restart
// request and the next time-out, and applies the expiry effects.
// Assumes one access per strobe cycle.
module wdt_regfile
    import wdt_bcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  bus_req_t             req,
    input  logic                 expire,
    output logic [2*REG_W-1:0]   timeout_q,
    output logic [2*REG_W-1:0]   timeout_nxt,
    output logic                 restart,
    output logic                 fire_rst,
    output logic [REG_W-1:0]     rdata,
    output logic                 wd_flag,
    output logic                 irq_flag,
    output logic                 irq_pin,
    output logic                 ctl_en
);
    logic [REG_W-1:0] lo_q, hi_q;
    logic steer_q, en_q, wd_q, irq_q, pin_q;
    logic wd_n, irq_n, pin_n, en_n;
    logic hit_lo, hit_hi, hit_fl, hit_ct;
    logic fire_irq;

    assign hit_lo = req.sel && (req.addr == ADDR_TO_LO);
    assign hit_hi = req.sel && (req.addr == ADDR_TO_HI);
    assign hit_fl = req.sel && (req.addr == ADDR_FLAGS);
    assign hit_ct = req.sel && (req.addr == ADDR_CTRL);

    assign restart     = hit_lo || hit_hi;
    assign timeout_q   = {hi_q, lo_q};
    assign timeout_nxt = {(hit_hi && req.wr) ? req.wdata : hi_q,
                          (hit_lo && req.wr) ? req.wdata : lo_q};

    assign fire_irq = expire && en_q && !steer_q;
    assign fire_rst = expire && en_q && steer_q;

    // Next flag, pin and enable state: clears first, expiry sets win.
    always_comb begin
        wd_n  = wd_q;
        irq_n = irq_q;
        pin_n = pin_q;
        en_n  = en_q;
        if (hit_fl && !req.wr) begin
            wd_n  = 1'b0;
            irq_n = 1'b0;
        end
        if (hit_fl && req.wr) begin
            wd_n  = wd_q  && req.wdata[FLAG_WD_BIT];
            irq_n = irq_q && req.wdata[FLAG_IRQ_BIT];
        end
        if (!irq_n) begin
            pin_n = 1'b0;
        end
        if (hit_ct && req.wr) begin
            en_n = req.wdata[CTRL_EN_BIT];
        end
        if (expire) begin
            wd_n = 1'b1;
        end
        if (fire_irq || fire_rst) begin
            irq_n = 1'b1;
        end
        if (fire_irq) begin
            pin_n = 1'b1;
        end
        if (fire_rst) begin
            en_n = 1'b0;
        end
    end

    // State registers updated from the bus and the expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            steer_q <= 1'b0;
            en_q    <= 1'b0;
            wd_q    <= 1'b0;
            irq_q   <= 1'b0;
            pin_q   <= 1'b0;
        end else begin
            lo_q  <= timeout_nxt[REG_W-1:0];
            hi_q  <= timeout_nxt[2*REG_W-1:REG_W];
            if (hit_ct && req.wr) begin
                steer_q <= req.wdata[CTRL_STEER_BIT];
            end
            en_q  <= en_n;
            wd_q  <= wd_n;
            irq_q <= irq_n;
            pin_q <= pin_n;
        end
    end

    // Read data multiplexer, active only during a read strobe.
    always_comb begin
        rdata = '0;
        if (req.sel && !req.wr) begin
            case (req.addr)
                ADDR_TO_LO: rdata = lo_q;
                ADDR_TO_HI: rdata = hi_q;
                ADDR_FLAGS: begin
                    rdata[FLAG_WD_BIT]  = wd_q;
                    rdata[FLAG_IRQ_BIT] = irq_q;
                end
                ADDR_CTRL: begin
                    rdata[CTRL_EN_BIT]    = en_q;
                    rdata[CTRL_STEER_BIT] = steer_q;
                end
                default: rdata = '0;
            endcase
        end
    end

    assign wd_flag  = wd_q;
    assign irq_flag = irq_q;
    assign irq_pin  = pin_q;
    assign ctl_en   = en_q;
endmodule

// File: rtl/wdt_bcd_steer.sv
// Top: BCD watchdog with expiry steering. Ties the register file, the
// BCD counter and the reset pulse timer together. Assumes tick_100hz is
// a single-cycle pulse in the clk domain.
module wdt_bcd_steer
    import wdt_bcd_pkg::*;
#(
    parameter int unsigned RST_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              wd_flag,
    output logic              irq_flag,
    output logic              irq_drive,
    output logic              rst_drive
);
    localparam int unsigned DIGITS = (2 * REG_W) / DIGIT_W;

    bus_req_t            req;
    logic [2*REG_W-1:0]  timeout_q, timeout_nxt;
    logic                restart, fire_rst, expire, armed, ctl_en;

    assign req   = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};
    assign armed = (timeout_q != '0);

    wdt_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .expire      (expire),
        .timeout_q   (timeout_q),
        .timeout_nxt (timeout_nxt),
        .restart     (restart),
        .fire_rst    (fire_rst),
        .rdata       (bus_rdata),
        .wd_flag     (wd_flag),
        .irq_flag    (irq_flag),
        .irq_pin     (irq_drive),
        .ctl_en      (ctl_en)
    );

    wdt_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_100hz),
        .armed      (armed),
        .load       (restart),
        .load_val   (timeout_nxt),
        .reload_val (timeout_q),
        .expire     (expire)
    );

    wdt_rst_pulse #(.PULSE_TICKS(RST_TICKS)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_100hz),
        .start  (fire_rst),
        .active (rst_drive)
    );
endmodule

// File: rtl/wdt_bcd_steer_chk.sv
// Checker: temporal properties of the watchdog, bound to the top module.
module wdt_bcd_steer_chk
    import wdt_bcd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_100hz,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              armed,
    input logic              expire,
    input logic              ctl_en,
    input logic              wd_flag,
    input logic              irq_flag,
    input logic              irq_drive,
    input logic              rst_drive
);
    assert_flag_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(tick_100hz));

    assert_idle_no_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !expire);

    assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive |-> irq_flag);

    assert_one_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_drive && $rose(rst_drive)));

    assert_rst_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_drive) |-> !ctl_en);

    assert_rst_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_drive) && !$past(tick_100hz)) |-> rst_drive);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_FLAGS && !tick_100hz)
        |=> (!wd_flag && !irq_flag && !irq_drive));
endmodule

bind wdt_bcd_steer wdt_bcd_steer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_100hz (tick_100hz),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .armed      (armed),
    .expire     (expire),
    .ctl_en     (ctl_en),
    .wd_flag    (wd_flag),
    .irq_flag   (irq_flag),
    .irq_drive  (irq_drive),
    .rst_drive  (rst_drive)
);

// File: tb/wdt_bcd_steer_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps time-outs and routing modes, with periods computed from BCD.
module wdt_bcd_steer_tb_top;
    localparam int RST_TICKS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wd_flag, irq_flag, irq_drive, rst_drive;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    wdt_bcd_steer #(.RST_TICKS(RST_TICKS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick_100hz),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wd_flag    (wd_flag),
        .irq_flag   (irq_flag),
        .irq_drive  (irq_drive),
        .rst_drive  (rst_drive)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] to_bcd(input int n);
        return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    // One-cycle bus access, optionally with a tick; rdata is sampled before the edge.
    task automatic bus(input logic wr, input logic [4:0] a, input logic [7:0] d,
                       input logic tk, output logic [7:0] r);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; tick_100hz = tk;
        #1 r = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_100hz = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_100hz = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_100hz = 1'b0;
        end
    endtask

    task automatic set_timeout(input int n);
        logic [15:0] b;
        logic [7:0] r;
        b = to_bcd(n);
        bus(1'b1, 5'h0D, b[15:8], 1'b0, r);
        bus(1'b1, 5'h0C, b[7:0], 1'b0, r);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus(1'b0, 5'h0C, 8'h00, 1'b0, rd); check("R1 lo", rd, 0);
        bus(1'b0, 5'h0D, 8'h00, 1'b0, rd); check("R1 hi", rd, 0);
        bus(1'b0, 5'h0E, 8'h00, 1'b0, rd); check("R1 flags", rd, 0);
        bus(1'b0, 5'h0F, 8'h00, 1'b0, rd); check("R1 ctrl", rd, 0);
        check("R1 pins", {wd_flag, irq_flag, irq_drive, rst_drive}, 0);

        // R4: disabled with zero time-out
        ticks(50);
        check("R4 no expiry", wd_flag, 0);

        // R2/R5: sweep periods with enable off
        for (int n = 1; n <= 25; n++) begin
            set_timeout(n);
            ticks(n - 1);
            check("R2 early", wd_flag, 0);
            ticks(1);
            check("R2 expiry", wd_flag, 1);
            check("R5 no irq when disabled", {irq_flag, irq_drive, rst_drive}, 0);
            bus(1'b0, 5'h0E, 8'h00, 1'b0, rd);
            check("R9 read value", rd, 8'h02);
            check("R9 cleared", wd_flag, 0);
        end

        // R2: borrow across digits, 100 and 1000 ticks
        set_timeout(100);
        ticks(99);  check("R2 100 early", wd_flag, 0);
        ticks(1);   check("R2 100", wd_flag, 1);
        bus(1'b0, 5'h0E, 8'h00, 1'b0, rd);
        set_timeout(1000);
        ticks(999); check("R2 1000 early", wd_flag, 0);
        ticks(1);   check("R2 1000", wd_flag, 1);
        bus(1'b0, 5'h0E, 8'h00, 1'b0, rd);

        // R8: self reload
        set_timeout(7);
        ticks(7);
        bus(1'b0, 5'h0E, 8'h00, 1'b0, rd);
        ticks(6);   check("R8 early", wd_flag, 0);
        ticks(1);   check("R8 reload", wd_flag, 1);
        bus(1'b0, 5'h0E, 8'h00, 1'b0, rd);

        // R3: read and write restart the period
        set_timeout(5);
        ticks(3);
        bus(1'b0, 5'h0D, 8'h00, 1'b0, rd);
        ticks(4);   check("R3 read restart", wd_flag, 0);
        bus(1'b1, 5'h0C, 8'h05, 1'b1, rd);
        ticks(4);   check("R3 write restart", wd_flag, 0);
        ticks(1);   check("R3 full period", wd_flag, 1);
        bus(1'b0, 5'h0E, 8'h00, 1'b0, rd);

        // R6 and R10: interrupt route, then partial clears
        bus(1'b1, 5'h0F, 8'h02, 1'b0, rd);
        set_timeout(3);
        ticks(3);
        check("R6 flags", {wd_flag, irq_flag}, 2'b11);
        check("R6 irq pin", irq_drive, 1);
        check("R6 no reset", rst_drive, 0);
        bus(1'b1, 5'h0E, 8'h01, 1'b0, rd);
        check("R10 wd cleared irq kept", {wd_flag, irq_flag, irq_drive}, 3'b011);
        bus(1'b1, 5'h0E, 8'h00, 1'b0, rd);
        check("R10 irq cleared", {wd_flag, irq_flag, irq_drive}, 3'b000);

        // R11: expiry and read clear in the same cycle
        set_timeout(2);
        ticks(1);
        bus(1'b0, 5'h0E, 8'h00, 1'b1, rd);
        check("R11 read value", rd, 0);
        check("R11 set wins", {wd_flag, irq_flag, irq_drive}, 3'b111);
        bus(1'b0, 5'h0E, 8'h00, 1'b0, rd);

        // R7: reset route, pulse length and enable clear
        bus(1'b1, 5'h0F, 8'h03, 1'b0, rd);
        set_timeout(3);
        ticks(3);
        check("R7 reset pin", rst_drive, 1);
        check("R7 flags", {wd_flag, irq_flag, irq_drive}, 3'b110);
        bus(1'b0, 5'h0F, 8'h00, 1'b0, rd);
        check("R7 enable cleared", rd, 8'h01);
        for (int k = 1; k <= RST_TICKS; k++) begin
            ticks(1);
            check("R7 pulse width", rst_drive, (k < RST_TICKS) ? 1 : 0);
        end
        check("R7 no irq pin", irq_drive, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule